// File: doc/BRIEF.md
# Nineteen-Level Cascaded Inverter Modulator

This block produces the switching states for an inverter built from three full bridges whose outputs are summed through cascaded transformers. One bridge is a fast chopping bridge on a half-unit winding. The other two are slow level bridges on windings of one unit and three units. A signed command sample arrives as sign and magnitude. The block quantizes the magnitude against nine equally spaced thresholds into a level `n` (0 to 9) and a remainder above the level's lower threshold. From these it derives three ternary switching functions.

The chopping bridge changes pulse polarity from one level to the next. Each coarse step of the level bridges is therefore split into two half-steps. The chopping pulse width tracks the remainder and is set by a free-running carrier counter. The command is sampled once per carrier period, at the counter wrap, so no switching function changes in the middle of a period.

In half-step units the instantaneous output equals chop + 2·levelA + 6·levelB. Averaged over a carrier period it rises continuously from n−1 to n as the remainder grows, for n from 1 to 9.

Top module: `cascade19_mod`

## Requirements
- R1: While `rst_n` is low, and after release until the first carrier wrap, all three switching outputs are 0.
- R2: The level n is the number of thresholds k·STEP (k = 1 to 9) that are at or below `cmd_mag`. The remainder is `cmd_mag` − n·STEP. With STEP = 455, a magnitude of 454 gives level 0 and 455 gives level 1.
- R3: At level 0, all three switching functions are 0 for the whole period, whatever the sign.
- R4: For a positive command, the chopping output takes only the values 0 and P. P is +1 for odd n and −1 for even n with n > 0.
- R5: Let c be the carrier count and r the remainder. For odd n, the chopping bridge is active (nonzero) when c·STEP < r·PERIOD. For even n > 0, it is active when that comparison is false. Over one period the active count is therefore the number of such c, or PERIOD minus that number.
- R6: For a positive command, level bridge A takes k = ((n+2)/2) mod 3 with integer division. It outputs −1 for k = 0, 0 for k = 1 and +1 for k = 2.
- R7: For a positive command, level bridge B outputs 0 for n < 4 and +1 for n ≥ 4.
- R8: When `cmd_neg` is 1, all three switching functions are the negation of the values for the same magnitude with a positive sign.
- R9: The command is captured only at the carrier wrap, the cycle after count PERIOD−1. A command change inside a period leaves all outputs unchanged until the next wrap.
- R10: Each switching output is encoded in two bits: 01 is +1, 00 is 0 and 11 is −1. The code 10 never appears.
- R11: The carrier counts 0 to PERIOD−1 and wraps, so the output pattern repeats every PERIOD cycles for a constant command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Modulator clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronized inside |
| cmd_neg | input | 1 | Command sign, 1 for negative |
| cmd_mag | input | MAG_W | Command magnitude |
| chop_sf | output | 2 | Chopping bridge switching function |
| lvla_sf | output | 2 | Unit-winding level bridge switching function |
| lvlb_sf | output | 2 | Triple-winding level bridge switching function |

## Verification
The bench targets the threshold edges: 454 against 455, zero remainder at odd and even levels, and a remainder one below the step. At these points an off-by-one comparator shifts the level, or an unreversed even-level duty gives a full pulse where none belongs. Level 9 at full scale and the zero-magnitude negative command cover the extremes. At those extremes a wrong mod-3 index or a missing level-0 override would show as a wrong level-bridge state. One directed test changes the command in mid-period. A design that captured the command outside the wrap would change the level bridges early. The bench also checks that the pulse pattern repeats every carrier period. A wrong wrap count would break that repetition.

// File: rtl/c19_pkg.sv
package c19_pkg;

  typedef logic [1:0] tern_t;

  localparam tern_t TERN_POS  = 2'b01;
  localparam tern_t TERN_ZERO = 2'b00;
  localparam tern_t TERN_NEG  = 2'b11;

  function automatic tern_t tern_flip(input tern_t v);
    tern_t r;
    case (v)
      TERN_POS: r = TERN_NEG;
      TERN_NEG: r = TERN_POS;
      default:  r = TERN_ZERO;
    endcase
    return r;
  endfunction

  function automatic int tern_val(input tern_t v);
    int r;
    case (v)
      TERN_POS: r = 1;
      TERN_NEG: r = -1;
      default:  r = 0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/c19_quantizer.sv
module c19_quantizer #(
  parameter int MAG_W = 12,
  parameter int STEP  = 455,
  parameter int NLEV  = 9,
  localparam int LVL_W = $clog2(NLEV + 1)
) (
  input  logic [MAG_W-1:0] mag,
  output logic [LVL_W-1:0] lvl,
  output logic [MAG_W-1:0] rem
);

  localparam int WW = MAG_W + LVL_W + 1;

  logic [NLEV-1:0] therm;
  logic [WW-1:0]   mag_w;
  logic [WW-1:0]   base_w;
  logic [WW-1:0]   diff_w;

  assign mag_w = {{(WW-MAG_W){1'b0}}, mag};

  for (genvar k = 1; k <= NLEV; k++) begin : g_thr
    localparam logic [WW-1:0] THR = WW'(k * STEP);
    assign therm[k-1] = (mag_w >= THR);
  end

  always_comb begin
    lvl = '0;
    for (int k = 0; k < NLEV; k++) begin
      if (therm[k]) lvl = lvl + LVL_W'(1);
    end
  end

  always_comb begin
    base_w = WW'(lvl) * WW'(STEP);
    diff_w = mag_w - base_w;
    rem    = diff_w[MAG_W-1:0];
  end

endmodule

// File: rtl/c19_carrier.sv
module c19_carrier #(
  parameter int PERIOD = 5000,
  localparam int CNT_W = $clog2(PERIOD)
) (
  input  logic             clk,
  input  logic             rst_ns,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);

  logic [CNT_W-1:0] cnt_nxt;

  assign wrap = (cnt == CNT_W'(PERIOD - 1));

  always_comb begin
    if (wrap) cnt_nxt = '0;
    else      cnt_nxt = cnt + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) cnt <= '0;
    else         cnt <= cnt_nxt;
  end

endmodule

// File: rtl/c19_mapper.sv
module c19_mapper
  import c19_pkg::*;
#(
  parameter int MAG_W  = 12,
  parameter int STEP   = 455,
  parameter int PERIOD = 5000,
  parameter int LVL_W  = 4,
  parameter int CNT_W  = 13
) (
  input  logic [LVL_W-1:0] lvl,
  input  logic             neg,
  input  logic [MAG_W-1:0] rem,
  input  logic [CNT_W-1:0] cnt,
  output tern_t            chop,
  output tern_t            lvla,
  output tern_t            lvlb
);

  localparam int PW = MAG_W + CNT_W + 2;

  logic [PW-1:0] prod_c;
  logic [PW-1:0] prod_r;
  logic          below;
  logic          odd;
  logic          on;
  tern_t         chop_p;
  tern_t         lvla_p;
  tern_t         lvlb_p;
  int unsigned   half;

  assign prod_c = PW'(cnt) * PW'(STEP);
  assign prod_r = PW'(rem) * PW'(PERIOD);
  assign below  = (prod_c < prod_r);
  assign odd    = lvl[0];

  always_comb begin
    if (lvl == '0) on = 1'b0;
    else if (odd)  on = below;
    else           on = !below;
  end

  always_comb begin
    if (!on)      chop_p = TERN_ZERO;
    else if (odd) chop_p = TERN_POS;
    else          chop_p = TERN_NEG;
  end

  always_comb begin
    half = (32'(lvl) + 32'd2) / 32'd2;
    case (half % 32'd3)
      32'd0:   lvla_p = TERN_NEG;
      32'd2:   lvla_p = TERN_POS;
      default: lvla_p = TERN_ZERO;
    endcase
    if (lvl == '0) lvla_p = TERN_ZERO;
  end

  assign lvlb_p = (lvl >= LVL_W'(4)) ? TERN_POS : TERN_ZERO;

  assign chop = neg ? tern_flip(chop_p) : chop_p;
  assign lvla = neg ? tern_flip(lvla_p) : lvla_p;
  assign lvlb = neg ? tern_flip(lvlb_p) : lvlb_p;

endmodule

// File: rtl/cascade19_mod.sv
module cascade19_mod
  import c19_pkg::*;
#(
  parameter int MAG_W  = 12,
  parameter int STEP   = 455,
  parameter int NLEV   = 9,
  parameter int PERIOD = 5000,
  localparam int LVL_W = $clog2(NLEV + 1),
  localparam int CNT_W = $clog2(PERIOD)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_neg,
  input  logic [MAG_W-1:0] cmd_mag,
  output logic [1:0]       chop_sf,
  output logic [1:0]       lvla_sf,
  output logic [1:0]       lvlb_sf
);

  logic             rst_meta;
  logic             rst_ns;
  logic [CNT_W-1:0] carrier_cnt;
  logic             carrier_wrap;
  logic [LVL_W-1:0] q_lvl;
  logic [MAG_W-1:0] q_rem;
  logic [LVL_W-1:0] lat_lvl;
  logic [MAG_W-1:0] lat_rem;
  logic             lat_neg;
  logic [LVL_W-1:0] lat_lvl_nxt;
  logic [MAG_W-1:0] lat_rem_nxt;
  logic             lat_neg_nxt;
  tern_t            chop_t;
  tern_t            lvla_t;
  tern_t            lvlb_t;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_ns   <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_ns   <= rst_meta;
    end
  end

  c19_carrier #(.PERIOD(PERIOD)) u_carrier (
    .clk    (clk),
    .rst_ns (rst_ns),
    .cnt    (carrier_cnt),
    .wrap   (carrier_wrap)
  );

  c19_quantizer #(.MAG_W(MAG_W), .STEP(STEP), .NLEV(NLEV)) u_quant (
    .mag (cmd_mag),
    .lvl (q_lvl),
    .rem (q_rem)
  );

  always_comb begin
    lat_lvl_nxt = q_lvl;
    lat_rem_nxt = q_rem;
    lat_neg_nxt = cmd_neg;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      lat_lvl <= '0;
      lat_rem <= '0;
      lat_neg <= 1'b0;
    end else if (carrier_wrap) begin
      lat_lvl <= lat_lvl_nxt;
      lat_rem <= lat_rem_nxt;
      lat_neg <= lat_neg_nxt;
    end
  end

  c19_mapper #(
    .MAG_W  (MAG_W),
    .STEP   (STEP),
    .PERIOD (PERIOD),
    .LVL_W  (LVL_W),
    .CNT_W  (CNT_W)
  ) u_map (
    .lvl  (lat_lvl),
    .neg  (lat_neg),
    .rem  (lat_rem),
    .cnt  (carrier_cnt),
    .chop (chop_t),
    .lvla (lvla_t),
    .lvlb (lvlb_t)
  );

  assign chop_sf = chop_t;
  assign lvla_sf = lvla_t;
  assign lvlb_sf = lvlb_t;

endmodule

// File: rtl/c19_checker.sv
module c19_checker #(
  parameter int PERIOD = 5000,
  parameter int CNT_W  = 13
) (
  input logic             clk,
  input logic             rst_ns,
  input logic [CNT_W-1:0] cnt,
  input logic [1:0]       chop,
  input logic [1:0]       lvla,
  input logic [1:0]       lvlb
);

  function automatic int sv(input logic [1:0] v);
    return (v == 2'b01) ? 1 : ((v == 2'b11) ? -1 : 0);
  endfunction

  int hsum;
  assign hsum = sv(chop) + 2 * sv(lvla) + 6 * sv(lvlb);

  // R10: the unused code never appears on any bridge
  assert_code_legal_R10: assert property (@(posedge clk) disable iff (!rst_ns)
    (chop != 2'b10) && (lvla != 2'b10) && (lvlb != 2'b10));

  // R9: level bridges only move on the first count after a wrap
  assert_bridge_hold_R9: assert property (@(posedge clk) disable iff (!rst_ns)
    (cnt != '0) |-> ($stable(lvla) && $stable(lvlb)));

  // R7 and R8: half-step sum follows the sign of the triple-winding bridge
  assert_sum_polarity_R7: assert property (@(posedge clk) disable iff (!rst_ns)
    ((lvlb == 2'b01) |-> (hsum > 0)) and ((lvlb == 2'b11) |-> (hsum < 0)));

  // R11: carrier stays inside one period and wraps to zero
  assert_carrier_range_R11: assert property (@(posedge clk) disable iff (!rst_ns)
    (cnt == CNT_W'(PERIOD - 1)) |=> (cnt == '0));

endmodule

bind cascade19_mod c19_checker #(.PERIOD(PERIOD), .CNT_W(CNT_W)) u_chk (
  .clk    (clk),
  .rst_ns (rst_ns),
  .cnt    (carrier_cnt),
  .chop   (chop_sf),
  .lvla   (lvla_sf),
  .lvlb   (lvlb_sf)
);

// File: tb/cascade19_mod_tb.sv
`timescale 1ns/1ps
module cascade19_mod_tb;

  localparam int MAG_W  = 12;
  localparam int STEP   = 455;
  localparam int PERIOD = 20;
  localparam int NV     = 17;

  // columns: neg, mag, chop polarity, lvlA, lvlB, active count per period
  localparam int VEC [NV][6] = '{
    '{0,    0,  0,  0,  0,  0},
    '{0,  454,  0,  0,  0,  0},
    '{0,  455,  1,  0,  0,  0},
    '{0,  682,  1,  0,  0, 10},
    '{0,  910, -1,  1,  0, 20},
    '{0, 1137, -1,  1,  0, 10},
    '{0, 1500,  1,  1,  0,  6},
    '{0, 1820, -1, -1,  1, 20},
    '{0, 2400,  1, -1,  1,  6},
    '{0, 2800, -1,  0,  1, 16},
    '{0, 3300,  1,  0,  1,  6},
    '{0, 3639,  1,  0,  1, 20},
    '{0, 3800, -1,  1,  1, 12},
    '{0, 4095,  1,  1,  1,  0},
    '{1, 1137,  1, -1,  0, 10},
    '{1, 2400, -1,  1, -1,  6},
    '{1,    0,  0,  0,  0,  0}
  };

  logic             clk;
  logic             rst_n;
  logic             cmd_neg;
  logic [MAG_W-1:0] cmd_mag;
  logic [1:0]       chop_sf;
  logic [1:0]       lvla_sf;
  logic [1:0]       lvlb_sf;

  int n_chk;
  int n_bad;
  bit done;

  cascade19_mod #(.MAG_W(MAG_W), .STEP(STEP), .PERIOD(PERIOD)) u_dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .cmd_neg (cmd_neg),
    .cmd_mag (cmd_mag),
    .chop_sf (chop_sf),
    .lvla_sf (lvla_sf),
    .lvlb_sf (lvlb_sf)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic int dec(input logic [1:0] v);
    case (v)
      2'b01:   return 1;
      2'b11:   return -1;
      2'b00:   return 0;
      default: return 99;
    endcase
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic run_vec(input int idx);
    int a_cnt, bad_pol, a0, b0, drift, illegal;
    string tg;
    cmd_neg = VEC[idx][0][0];
    cmd_mag = MAG_W'(VEC[idx][1]);
    tick(PERIOD + 3);
    a_cnt = 0; bad_pol = 0; drift = 0; illegal = 0;
    a0 = dec(lvla_sf); b0 = dec(lvlb_sf);
    for (int i = 0; i < PERIOD; i++) begin
      if (dec(chop_sf) == 99 || dec(lvla_sf) == 99 || dec(lvlb_sf) == 99) illegal++;
      if (dec(chop_sf) != 0) begin
        a_cnt++;
        if (dec(chop_sf) != VEC[idx][2]) bad_pol++;
      end
      if (dec(lvla_sf) != a0 || dec(lvlb_sf) != b0) drift++;
      tick(1);
    end
    tg = $sformatf("vec%0d mag=%0d neg=%0d", idx, VEC[idx][1], VEC[idx][0]);
    chk({"R6 R8 R2 lvlA ", tg}, a0, VEC[idx][3]);
    chk({"R7 R8 lvlB ", tg}, b0, VEC[idx][4]);
    chk({"R5 R3 active count ", tg}, a_cnt, VEC[idx][5]);
    chk({"R4 R8 chop polarity errors ", tg}, bad_pol, 0);
    chk({"R9 bridges steady in period ", tg}, drift, 0);
    chk({"R10 illegal codes ", tg}, illegal, 0);
  endtask

  initial begin
    int seen_on, pos, same;
    int pat [2*PERIOD];
    n_chk = 0; n_bad = 0; done = 1'b0;
    rst_n = 1'b0; cmd_neg = 1'b0; cmd_mag = MAG_W'(3000);
    tick(3);
    // R1: outputs quiet in reset
    chk("R1 chop in reset", dec(chop_sf), 0);
    chk("R1 lvlA in reset", dec(lvla_sf), 0);
    chk("R1 lvlB in reset", dec(lvlb_sf), 0);
    rst_n = 1'b1;
    tick(10);
    // R1 and R9: no capture before the first wrap
    chk("R1 chop before first wrap", dec(chop_sf), 0);
    chk("R1 lvlB before first wrap", dec(lvlb_sf), 0);

    for (int v = 0; v < NV; v++) run_vec(v);

    // R11: pattern repeats every carrier period (level 1, remainder 227)
    cmd_neg = 1'b0; cmd_mag = MAG_W'(682);
    tick(PERIOD + 3);
    for (int i = 0; i < 2*PERIOD; i++) begin
      pat[i] = dec(chop_sf);
      tick(1);
    end
    same = 0;
    for (int i = 0; i < PERIOD; i++) if (pat[i] == pat[i+PERIOD]) same++;
    chk("R11 pattern period", same, PERIOD);

    // R9: mid-period change is held off until the wrap
    seen_on = 0;
    pos = 0;
    for (int i = 0; i < 3*PERIOD && pos == 0; i++) begin
      if (dec(chop_sf) == 1) seen_on = 1;
      else if (seen_on == 1) pos = 1;
      if (pos == 0) tick(1);
    end
    chk("R9 found pulse edge", pos, 1);
    cmd_neg = 1'b1; cmd_mag = MAG_W'(1820);
    same = 0;
    for (int i = 0; i < PERIOD - 11; i++) begin
      tick(1);
      if (dec(lvla_sf) == 0 && dec(lvlb_sf) == 0 && dec(chop_sf) == 0) same++;
    end
    chk("R9 held through period", same, PERIOD - 11);
    tick(1);
    chk("R9 lvlB after wrap", dec(lvlb_sf), -1);
    chk("R9 lvlA after wrap", dec(lvla_sf), 1);
    chk("R9 chop after wrap", dec(chop_sf), 1);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule